// File: doc/BRIEF.md
# DRAM Refresh and Calibration Scheduler

This block decides when a memory controller serving two DRAM ranks must refresh, and when it must run ZQ calibration and PVT compensation updates. One shared prescaler divides the core clock into a tick of roughly 100 ns. Three interval timers count that tick: one for refresh, one for ZQ calibration and one for PVT updates. The ZQ and PVT timers each produce a single-cycle request pulse when they expire.

When the refresh timer expires, a configurable number of refresh rounds is added to a saturating backlog counter. A sequencer then works through the backlog one round at a time. In each round it refreshes every rank this block owns, rank 0 before rank 1. It uses a request/acknowledge handshake per rank and waits a programmable recovery window after each acknowledge.

A hold output tells the command path to stop issuing new commands. It can be raised while refresh work is pending, during the recovery window after each refresh, or in both cases.

Top module: `refresh_cal_sched`

## Requirements
- R1: The prescaler emits one tick every `cfg_tick_div` clock cycles. When `cfg_tick_div` is 0 no ticks occur, so no ZQ, PVT or refresh activity takes place.
- R2: With `cfg_zq_en` high and `cfg_zq_ival` nonzero, `zq_pulse` is a one-cycle pulse repeating every `cfg_tick_div * cfg_zq_ival` cycles. With the enable low or the interval 0, it never pulses.
- R3: With `cfg_pvt_en` high and `cfg_pvt_ival` nonzero, `pvt_pulse` is a one-cycle pulse repeating every `cfg_tick_div * cfg_pvt_ival` cycles. With the enable low or the interval 0, it never pulses.
- R4: Each expiry of the refresh interval (`cfg_tick_div * cfg_ref_ival` cycles) yields `cfg_ref_burst` refresh rounds. Each owned rank sees exactly one request per round.
- R5: `ref_req` has at most one bit set. A request stays high until the matching `ref_ack` bit is sampled high. When both ranks are owned, the requests alternate and start with rank 0.
- R6: `cfg_rank_own[i]` = 1 lets the block refresh rank i; a rank not owned is never requested. If `cfg_auto_en` is 0, no rank is owned, or `cfg_ref_ival` or `cfg_ref_burst` is 0, no new refresh work is created and the backlog is cleared.
- R7: Interval expiries that arrive while earlier rounds are still outstanding add to a backlog that saturates at 15 rounds. Every backlogged round is later carried out.
- R8: With `cfg_hold_req_en` set, `cmd_hold` is high whenever refresh rounds are pending or a request is outstanding. This includes the cycle before the first request rises.
- R9: After each acknowledge, the sequencer waits `cfg_rfc_cycles` cycles before its next request. With `cfg_hold_post_en` set, `cmd_hold` is high for exactly those cycles.
- R10: During and right after reset, `ref_req`, `zq_pulse`, `pvt_pulse` and `cmd_hold` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tick_div | input | 8 | Clock cycles per tick (0 stops the tick) |
| cfg_ref_ival | input | 8 | Refresh interval in ticks |
| cfg_ref_burst | input | 3 | Refresh rounds per interval |
| cfg_rank_own | input | 2 | Per-rank refresh ownership |
| cfg_auto_en | input | 1 | Global automatic refresh enable |
| cfg_hold_req_en | input | 1 | Hold commands while refresh is pending |
| cfg_hold_post_en | input | 1 | Hold commands during the recovery window |
| cfg_rfc_cycles | input | 8 | Recovery window after each refresh, in cycles |
| cfg_zq_en | input | 1 | ZQ calibration request enable |
| cfg_zq_ival | input | 8 | ZQ interval in ticks |
| cfg_pvt_en | input | 1 | PVT update request enable |
| cfg_pvt_ival | input | 8 | PVT interval in ticks |
| ref_ack | input | 2 | Per-rank refresh acknowledge |
| ref_req | output | 2 | Per-rank refresh request |
| zq_pulse | output | 1 | ZQ calibration request pulse |
| pvt_pulse | output | 1 | PVT update request pulse |
| cmd_hold | output | 1 | Block new commands |

## Verification
The assertions check these properties on every cycle:
- At most one rank is requested at a time.
- A request persists until it is acknowledged.
- A ZQ or PVT pulse never lasts longer than one cycle when its interval exceeds one tick.
- A disabled pulse never fires.
- The hold is present whenever a request is outstanding or a recovery window has just started.

Only the bench scenarios can show the following:
- Exact pulse periods across random divider and interval settings.
- The number of rounds per interval and the rank-0-first alternation.
- Backlog accumulation and saturation while acknowledges are withheld.
- Cycle-exact recovery windows.

// File: rtl/refsched_pkg.sv
// Shared types and constants for the refresh and calibration scheduler.
package refsched_pkg;
    localparam int NUM_RANKS  = 2;
    localparam int NUM_TIMERS = 3;
    localparam int TMR_REF = 0;
    localparam int TMR_ZQ  = 1;
    localparam int TMR_PVT = 2;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_GAP  = 2'd2
    } sq_state_t;
endpackage

// File: rtl/refsched_prescaler.sv
// Shared tick prescaler.
// Emits a registered one-cycle tick every DIV clock cycles.
// Assumes: div == 0 means "no tick"; a change of div takes effect at the
// next wrap or immediately if the count already exceeds the new limit.
module refsched_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Count cycles and fire the tick when the divider limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || div == '0) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div - 1'b1) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/refsched_interval_timer.sv
// Tick-based interval timer.
// Produces a registered one-cycle pulse every PERIOD ticks.
// Assumes: tick is a single-cycle strobe. Disabling the timer or setting
// period to 0 returns the count to idle.
module refsched_interval_timer #(
    parameter int IVAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [IVAL_W-1:0] period,
    output logic              fire
);
    logic [IVAL_W-1:0] cnt_q;

    // Advance on each tick and wrap with a fire pulse at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || period == '0) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (tick) begin
                if (cnt_q >= period - 1'b1) begin
                    cnt_q <= '0;
                    fire  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/refsched_sequencer.sv
// Refresh round sequencer.
// Keeps a saturating backlog of refresh rounds. It performs each round as
// a request/acknowledge handshake to every owned rank, rank 0 first, with
// a recovery gap after each acknowledge. It also drives the command hold.
// Assumes: ref_ack is only meaningful for the rank currently requested;
// clear drops the backlog but lets an outstanding handshake finish.
module refsched_sequencer
    import refsched_pkg::*;
#(
    parameter int BURST_W = 3,
    parameter int RFC_W   = 8,
    parameter int PEND_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ival_fire,
    input  logic                 clear,
    input  logic [BURST_W-1:0]   burst,
    input  logic [NUM_RANKS-1:0] rank_own,
    input  logic [RFC_W-1:0]     rfc_cycles,
    input  logic                 hold_req_en,
    input  logic                 hold_post_en,
    input  logic [NUM_RANKS-1:0] ref_ack,
    output logic [NUM_RANKS-1:0] ref_req,
    output logic                 cmd_hold
);
    localparam int SUM_W = ((PEND_W > BURST_W) ? PEND_W : BURST_W) + 1;
    localparam logic [SUM_W-1:0] PEND_MAX = SUM_W'((1 << PEND_W) - 1);

    sq_state_t         state_q;
    logic              cur_q;
    logic              last_q;
    logic [PEND_W-1:0] pend_q;
    logic [RFC_W-1:0]  gap_q;

    logic              is_last;
    logic              ack_cur;
    logic              round_done;
    logic [SUM_W-1:0]  pend_sum;
    logic [SUM_W-1:0]  pend_next;

    // Decode whether the current rank closes the round and whether it was acked.
    always_comb begin
        is_last    = cur_q || !rank_own[1];
        ack_cur    = (state_q == SQ_REQ) && ref_ack[cur_q];
        round_done = ack_cur && is_last;
    end

    // Backlog arithmetic: add the burst on expiry, retire one per round, saturate.
    always_comb begin
        pend_sum = SUM_W'(pend_q) + (ival_fire ? SUM_W'(burst) : '0);
        if (round_done && pend_sum != '0) begin
            pend_sum = pend_sum - 1'b1;
        end
        pend_next = (pend_sum > PEND_MAX) ? PEND_MAX : pend_sum;
    end

    // Backlog register, cleared when automatic refresh is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_next[PEND_W-1:0];
        end
    end

    // Round state machine: idle -> request -> recovery gap -> next rank or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cur_q   <= 1'b0;
            last_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (pend_q != '0 && !clear && rank_own != '0) begin
                        cur_q   <= !rank_own[0];
                        state_q <= SQ_REQ;
                    end
                end
                SQ_REQ: begin
                    if (ack_cur) begin
                        last_q <= is_last;
                        if (rfc_cycles != '0) begin
                            gap_q   <= rfc_cycles;
                            state_q <= SQ_GAP;
                        end else if (is_last) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            cur_q <= 1'b1;
                        end
                    end
                end
                SQ_GAP: begin
                    if (gap_q <= RFC_W'(1)) begin
                        if (last_q) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            cur_q   <= 1'b1;
                            state_q <= SQ_REQ;
                        end
                    end else begin
                        gap_q <= gap_q - 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Request vector: one bit for the rank under handshake.
    always_comb begin
        ref_req = '0;
        if (state_q == SQ_REQ) begin
            ref_req[cur_q] = 1'b1;
        end
    end

    // Command hold: pending/outstanding work and/or the recovery gap.
    always_comb begin
        cmd_hold = (hold_req_en && (pend_q != '0 || state_q == SQ_REQ))
                || (hold_post_en && state_q == SQ_GAP);
    end
endmodule

// File: rtl/refresh_cal_sched.sv
// Refresh and calibration scheduler top.
// Ties one prescaler to three interval timers (refresh, ZQ, PVT) and feeds
// the refresh expiries into the round sequencer.
// Assumes: configuration inputs are quasi-static; all timers share the tick.
module refresh_cal_sched
    import refsched_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int IVAL_W  = 8,
    parameter int BURST_W = 3,
    parameter int RFC_W   = 8,
    parameter int PEND_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   cfg_tick_div,
    input  logic [IVAL_W-1:0]  cfg_ref_ival,
    input  logic [BURST_W-1:0] cfg_ref_burst,
    input  logic [1:0]         cfg_rank_own,
    input  logic               cfg_auto_en,
    input  logic               cfg_hold_req_en,
    input  logic               cfg_hold_post_en,
    input  logic [RFC_W-1:0]   cfg_rfc_cycles,
    input  logic               cfg_zq_en,
    input  logic [IVAL_W-1:0]  cfg_zq_ival,
    input  logic               cfg_pvt_en,
    input  logic [IVAL_W-1:0]  cfg_pvt_ival,
    input  logic [1:0]         ref_ack,
    output logic [1:0]         ref_req,
    output logic               zq_pulse,
    output logic               pvt_pulse,
    output logic               cmd_hold
);
    logic                    tick;
    logic                    ref_active;
    logic [NUM_TIMERS-1:0]   tmr_en;
    logic [IVAL_W-1:0]       tmr_period [NUM_TIMERS];
    logic [NUM_TIMERS-1:0]   tmr_fire;

    // Refresh is live only when enabled, some rank is owned and the fields are nonzero.
    always_comb begin
        ref_active = cfg_auto_en && (cfg_rank_own != '0)
                  && (cfg_ref_burst != '0) && (cfg_ref_ival != '0);
        tmr_en[TMR_REF]     = ref_active;
        tmr_en[TMR_ZQ]      = cfg_zq_en;
        tmr_en[TMR_PVT]     = cfg_pvt_en;
        tmr_period[TMR_REF] = cfg_ref_ival;
        tmr_period[TMR_ZQ]  = cfg_zq_ival;
        tmr_period[TMR_PVT] = cfg_pvt_ival;
    end

    refsched_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (cfg_tick_div),
        .tick (tick)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        refsched_interval_timer #(.IVAL_W(IVAL_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en    (tmr_en[g]),
            .period(tmr_period[g]),
            .fire  (tmr_fire[g])
        );
    end

    refsched_sequencer #(
        .BURST_W(BURST_W),
        .RFC_W  (RFC_W),
        .PEND_W (PEND_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ival_fire   (tmr_fire[TMR_REF]),
        .clear       (!ref_active),
        .burst       (cfg_ref_burst),
        .rank_own    (cfg_rank_own),
        .rfc_cycles  (cfg_rfc_cycles),
        .hold_req_en (cfg_hold_req_en),
        .hold_post_en(cfg_hold_post_en),
        .ref_ack     (ref_ack),
        .ref_req     (ref_req),
        .cmd_hold    (cmd_hold)
    );

    assign zq_pulse  = tmr_fire[TMR_ZQ];
    assign pvt_pulse = tmr_fire[TMR_PVT];
endmodule

// File: rtl/refresh_cal_sched_chk.sv
// Property checker for the refresh and calibration scheduler, bound to the top.
module refresh_cal_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_hold_req_en,
    input logic       cfg_hold_post_en,
    input logic [7:0] cfg_rfc_cycles,
    input logic       cfg_zq_en,
    input logic [7:0] cfg_zq_ival,
    input logic       cfg_pvt_en,
    input logic [7:0] cfg_pvt_ival,
    input logic [1:0] ref_ack,
    input logic [1:0] ref_req,
    input logic       zq_pulse,
    input logic       pvt_pulse,
    input logic       cmd_hold
);
    // R5: one rank at a time
    a_r5_one_rank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ref_req));

    // R5: request persists until acknowledged
    a_r5_hold_req0: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req[0] && !ref_ack[0]) |=> ref_req[0]);
    a_r5_hold_req1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req[1] && !ref_ack[1]) |=> ref_req[1]);

    // R2: single-cycle ZQ pulse, none while disabled
    a_r2_zq_single: assert property (@(posedge clk) disable iff (!rst_n)
        (zq_pulse && cfg_zq_ival > 8'd1) |=> !zq_pulse);
    a_r2_zq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_zq_en && $past(!cfg_zq_en)) |-> !zq_pulse);

    // R3: single-cycle PVT pulse, none while disabled
    a_r3_pvt_single: assert property (@(posedge clk) disable iff (!rst_n)
        (pvt_pulse && cfg_pvt_ival > 8'd1) |=> !pvt_pulse);
    a_r3_pvt_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pvt_en && $past(!cfg_pvt_en)) |-> !pvt_pulse);

    // R8: outstanding request implies hold
    a_r8_hold_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hold_req_en && ref_req != 2'b00) |-> cmd_hold);

    // R9: the recovery window opens with hold right after an acknowledge
    a_r9_post_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(ref_req[0]) || $fell(ref_req[1])) && cfg_hold_post_en
         && cfg_rfc_cycles != 8'd0) |-> cmd_hold);
endmodule

bind refresh_cal_sched refresh_cal_sched_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_hold_req_en (cfg_hold_req_en),
    .cfg_hold_post_en(cfg_hold_post_en),
    .cfg_rfc_cycles  (cfg_rfc_cycles),
    .cfg_zq_en       (cfg_zq_en),
    .cfg_zq_ival     (cfg_zq_ival),
    .cfg_pvt_en      (cfg_pvt_en),
    .cfg_pvt_ival    (cfg_pvt_ival),
    .ref_ack         (ref_ack),
    .ref_req         (ref_req),
    .zq_pulse        (zq_pulse),
    .pvt_pulse       (pvt_pulse),
    .cmd_hold        (cmd_hold)
);

// File: tb/test_refresh_cal_sched.sv
module test_refresh_cal_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_tick_div = '0;
    logic [7:0] cfg_ref_ival = '0;
    logic [2:0] cfg_ref_burst = '0;
    logic [1:0] cfg_rank_own = '0;
    logic       cfg_auto_en = 1'b0;
    logic       cfg_hold_req_en = 1'b0;
    logic       cfg_hold_post_en = 1'b0;
    logic [7:0] cfg_rfc_cycles = '0;
    logic       cfg_zq_en = 1'b0;
    logic [7:0] cfg_zq_ival = '0;
    logic       cfg_pvt_en = 1'b0;
    logic [7:0] cfg_pvt_ival = '0;
    logic [1:0] ref_ack = '0;
    logic [1:0] ref_req;
    logic       zq_pulse;
    logic       pvt_pulse;
    logic       cmd_hold;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    bit  resp_on = 1'b0;
    int  resp_delay = 0;

    always #2 clk = ~clk;

    refresh_cal_sched i_refresh_cal_sched (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int div, input int ival);
        return div * ival;
    endfunction

    function automatic int exp_rounds(input int fires, input int burst);
        int s = fires * burst;
        return (s > 15) ? 15 : s;
    endfunction

    // Acknowledge responder: acks the requested rank after resp_delay cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (resp_on && ref_req != 2'b00) begin
                automatic int r = ref_req[1] ? 1 : 0;
                repeat (resp_delay) @(negedge clk);
                ref_ack[r] = 1'b1;
                @(negedge clk);
                ref_ack = 2'b00;
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Period between two consecutive pulses on the selected output (0 = ZQ).
    task automatic measure(input bit pvt, output int period);
        int c = 0;
        do begin @(negedge clk); c++; end while (!(pvt ? pvt_pulse : zq_pulse) && c < 5000);
        c = 0;
        do begin @(negedge clk); c++; end while (!(pvt ? pvt_pulse : zq_pulse) && c < 5000);
        period = c;
    endtask

    task automatic count_pulses(input int n, output int zc, output int pc, output int rc);
        zc = 0; pc = 0; rc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            zc += zq_pulse; pc += pvt_pulse; rc += (ref_req != 2'b00);
        end
    endtask

    // Refresh window: counts requests, order and hold over K intervals.
    task automatic ref_window(input int div, input int ival, input int burst, input int own,
                              input int rfc, input int dly, input bit hreq, input bit hpost,
                              input int k);
        int  p, c, r0, r1, holdc, viol, order_bad;
        bit  prev0, prev1, hold_prev, expect1;
        cfg_auto_en = 0; resp_on = 0;
        cycles(4);
        cfg_tick_div = 8'(div); cfg_ref_ival = 8'(ival); cfg_ref_burst = 3'(burst);
        cfg_rank_own = 2'(own); cfg_rfc_cycles = 8'(rfc); resp_delay = dly;
        cfg_hold_req_en = hreq; cfg_hold_post_en = hpost;
        resp_on = 1; cfg_auto_en = 1;
        c = 0; hold_prev = 0;
        do begin hold_prev = cmd_hold; @(negedge clk); c++; end
        while (ref_req == 2'b00 && c < 5000);
        p = exp_period(div, ival);
        r0 = 0; r1 = 0; holdc = 0; viol = 0; order_bad = 0;
        prev0 = 0; prev1 = 0; expect1 = 0;
        for (int i = 0; i < k * p; i++) begin
            if (i > 0) @(negedge clk);
            if (ref_req[0] && !prev0) begin
                r0++;
                if (own == 3 && expect1) order_bad++;
                expect1 = 1;
            end
            if (ref_req[1] && !prev1) begin
                r1++;
                if (own == 3 && !expect1) order_bad++;
                expect1 = 0;
            end
            if (ref_req == 2'b11) viol++;
            if (hreq && ref_req != 2'b00 && !cmd_hold) viol++;
            holdc += cmd_hold;
            prev0 = ref_req[0]; prev1 = ref_req[1];
        end
        chk(r0 == ((own & 1) ? k * burst : 0), "R4/R6 rank0 requests", r0, (own & 1) ? k * burst : 0);
        chk(r1 == ((own & 2) ? k * burst : 0), "R4/R6 rank1 requests", r1, (own & 2) ? k * burst : 0);
        chk(order_bad == 0, "R5 rank0-first alternation", order_bad, 0);
        chk(viol == 0, "R5/R8 one-rank and hold-on-request", viol, 0);
        if (hreq) chk(hold_prev == 1'b1, "R8 hold before first request", int'(hold_prev), 1);
        if (hpost && !hreq) begin
            int exp_h = (r0 + r1) * rfc;
            chk(holdc == exp_h, "R9 post-refresh hold cycles", holdc, exp_h);
        end
        if (!hpost && !hreq) chk(holdc == 0, "R9 no hold when disabled", holdc, 0);
        cfg_auto_en = 0; resp_on = 0;
        cycles(60);
    endtask

    // Backlog: withhold acks over three intervals, then drain and count rounds.
    task automatic backlog(input int burst);
        int r0, r1;
        bit prev0, prev1;
        cfg_auto_en = 0; resp_on = 0;
        cycles(4);
        cfg_tick_div = 8'd4; cfg_ref_ival = 8'd10; cfg_ref_burst = 3'(burst);
        cfg_rank_own = 2'b11; cfg_rfc_cycles = 8'd0; resp_delay = 0;
        cfg_hold_req_en = 0; cfg_hold_post_en = 0;
        cfg_auto_en = 1;
        cycles(140);
        cfg_ref_ival = 8'd255;
        resp_on = 1;
        r0 = 0; r1 = 0; prev0 = 0; prev1 = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (ref_req[0] && !prev0) r0++;
            if (ref_req[1] && !prev1) r1++;
            prev0 = ref_req[0]; prev1 = ref_req[1];
        end
        chk(r0 == exp_rounds(3, burst), "R7 backlog rank0 rounds", r0, exp_rounds(3, burst));
        chk(r1 == exp_rounds(3, burst), "R7 backlog rank1 rounds", r1, exp_rounds(3, burst));
        cfg_auto_en = 0; resp_on = 0;
        cycles(40);
    endtask

    initial begin
        int per, zc, pc, rc;
        void'($urandom(32'd20240611));
        cycles(3);
        // R10: reset state
        chk(ref_req == 2'b00 && !zq_pulse && !pvt_pulse && !cmd_hold, "R10 outputs in reset",
            {ref_req, zq_pulse, pvt_pulse, cmd_hold}, 0);
        rst_n = 1'b1;
        cycles(2);
        chk(ref_req == 2'b00 && !zq_pulse && !pvt_pulse && !cmd_hold, "R10 outputs after reset",
            {ref_req, zq_pulse, pvt_pulse, cmd_hold}, 0);

        // R2/R3/R1: directed period corners, then random
        cfg_tick_div = 8'd1; cfg_zq_ival = 8'd1; cfg_zq_en = 1;
        cycles(3);
        measure(0, per);
        chk(per == exp_period(1, 1), "R2 ZQ period div=1 ival=1", per, 1);
        cfg_zq_en = 0;
        for (int t = 0; t < 4; t++) begin
            automatic int d  = 1 + int'($urandom_range(0, 9));
            automatic int zi = 1 + int'($urandom_range(0, 19));
            automatic int pi = 1 + int'($urandom_range(0, 19));
            cfg_zq_en = 0; cfg_pvt_en = 0;
            cycles(3);
            cfg_tick_div = 8'(d); cfg_zq_ival = 8'(zi); cfg_pvt_ival = 8'(pi);
            cfg_zq_en = 1; cfg_pvt_en = 1;
            measure(0, per);
            chk(per == exp_period(d, zi), "R1/R2 ZQ period", per, exp_period(d, zi));
            measure(1, per);
            chk(per == exp_period(d, pi), "R1/R3 PVT period", per, exp_period(d, pi));
        end

        // R2/R3: gated off by enable and by zero interval
        cfg_tick_div = 8'd2; cfg_zq_ival = 8'd3; cfg_pvt_ival = 8'd0;
        cfg_zq_en = 0; cfg_pvt_en = 1;
        cycles(2);
        count_pulses(100, zc, pc, rc);
        chk(zc == 0, "R2 ZQ disabled by enable", zc, 0);
        chk(pc == 0, "R3 PVT disabled by zero interval", pc, 0);

        // R1: zero divider stops every timer
        cfg_tick_div = 8'd0; cfg_zq_ival = 8'd2; cfg_pvt_ival = 8'd2;
        cfg_zq_en = 1; cfg_pvt_en = 1;
        cfg_ref_ival = 8'd2; cfg_ref_burst = 3'd1; cfg_rank_own = 2'b11; cfg_auto_en = 1;
        cycles(2);
        count_pulses(300, zc, pc, rc);
        chk(zc + pc + rc == 0, "R1 zero divider stops all activity", zc + pc + rc, 0);
        cfg_auto_en = 0; cfg_zq_en = 0; cfg_pvt_en = 0;

        // R6: auto disabled produces no requests
        cfg_tick_div = 8'd2;
        count_pulses(200, zc, pc, rc);
        chk(rc == 0, "R6 auto refresh disabled", rc, 0);

        // R4/R5/R6/R8/R9: directed windows
        ref_window(4, 25, 3, 3, 3, 1, 0, 1, 3);
        ref_window(4, 25, 2, 3, 0, 0, 1, 0, 3);
        ref_window(3, 30, 2, 2, 2, 1, 0, 1, 2);
        ref_window(5, 20, 1, 1, 4, 2, 0, 0, 3);
        // Random windows
        for (int t = 0; t < 3; t++) begin
            automatic int d   = 3 + int'($urandom_range(0, 2));
            automatic int iv  = 25 + int'($urandom_range(0, 5));
            automatic int b   = 1 + int'($urandom_range(0, 2));
            automatic int own = 1 + int'($urandom_range(0, 2));
            automatic int rfc = int'($urandom_range(0, 4));
            automatic int dl  = int'($urandom_range(0, 2));
            ref_window(d, iv, b, own, rfc, dl, 0, 1, 2);
        end

        // R7: backlog below and at saturation
        backlog(2);
        backlog(7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule